// File: doc/BRIEF.md
# Dual Gated Timer/Counter with Overflow Flags

This block holds two up-counting timer/counter channels that share one control byte and one mode byte. Each channel has five controls: a run bit, a gate bit, a source-select bit and two mode bits kept for software. It also has an overflow flag that the interrupt logic can read. A channel in timer mode advances once for each clock cycle in which the machine-cycle tick input is high. A channel in counter mode advances once for each falling edge seen on its external count pin, after that pin has been synchronized.

With gating on, a channel counts only while its external interrupt pin is high and its run bit is set. A power-down input stops both channels. An overflow sets the channel's flag. The flag is cleared when the interrupt controller reports that the channel's service routine has been entered, or software can rewrite it through the control byte. The control byte and the mode byte each read back through a port. The channel counts appear as two separate output words.

Top module: `gate_timer_pair`

## Requirements
- R1: After reset, both counts are 0, the control readback is 0x00, the mode readback is 0x00 and both overflow flags are 0.
- R2: A control write stores the byte. Its readback has channel 1 flag in bit 7, channel 1 run in bit 6, channel 0 flag in bit 5, channel 0 run in bit 4, and bits 3..0 kept as written. A mode write stores the byte. In each mode nibble, bit 3 is gate, bit 2 is source select, and bits 1..0 are stored only. Channel 1 uses bits 7..4 of the mode byte and channel 0 uses bits 3..0.
- R3: With source select 0 and the channel enabled, the count rises by exactly 1 for each clock cycle in which tick_i is high. It does not change in cycles where tick_i is low.
- R4: With the run bit clear, the count holds its value.
- R5: With gate 0, the external interrupt pin level does not affect counting. With gate 1, the channel counts only while its pin is high.
- R6: With source select 1, the count rises by 1 for each falling edge of the channel's count pin, and tick_i is ignored.
- R7: An increment from the all-ones count wraps the count to 0 and sets the channel flag on the same clock edge.
- R8: A pulse on a channel's vector acknowledge input clears that channel's flag and leaves the other channel's flag unchanged.
- R9: A control write loads both flags from bits 7 and 5. When a wrap happens in the same cycle as a control write or a vector acknowledge, the flag is set.
- R10: While pd_i is high, neither count changes.
- R11: The two channels run independently; the settings of one never change the other channel's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Machine-cycle tick, one increment per high cycle in timer mode |
| pd_i | input | 1 | Power-down, stops all counting |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| mode_we_i | input | 1 | Mode byte write strobe |
| mode_wdata_i | input | 8 | Mode byte write data |
| gate_pin_i | input | 2 | External interrupt pin level per channel, used for gating |
| cnt_pin_i | input | 2 | Asynchronous external count pin per channel |
| vec_ack_i | input | 2 | Service routine entered, per channel |
| ctl_o | output | 8 | Control byte readback including flags |
| mode_o | output | 8 | Mode byte readback |
| cnt0_o | output | CNT_W | Channel 0 count |
| cnt1_o | output | CNT_W | Channel 1 count |
| ovf_o | output | 2 | Overflow flags (interrupt requests) |

## Verification
Some properties are checked on every cycle:
- a stopped, gated-off or powered-down channel keeps its count;
- a count never moves by more than one per cycle;
- a wrap to zero always leaves the flag set;
- an acknowledge alone clears the flag;
- the count-pin edge detector never fires two cycles in a row;
- written control and mode bytes read back.

Other behaviour needs the bench's scenarios:
- the exact number of increments for a tick or edge pattern;
- the ordering between a wrap and a simultaneous write or acknowledge;
- that one channel's settings leave the other channel alone.

The bench covers these with a narrow counter, sweeping every combination of run, gate, pin level and power-down on both channels.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  localparam int NUM_CH = 2;

  // control byte: per channel a run bit and a flag bit above it
  function automatic int ctl_run_bit(input int ch);
    return 4 + 2 * ch;
  endfunction

  function automatic int ctl_flag_bit(input int ch);
    return 5 + 2 * ch;
  endfunction

  // mode byte: one nibble per channel
  function automatic int mode_ct_bit(input int ch);
    return 2 + 4 * ch;
  endfunction

  function automatic int mode_gate_bit(input int ch);
    return 3 + 4 * ch;
  endfunction
endpackage

// File: rtl/gtp_fall_det.sv
module gtp_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] sr_q;

  // idle-high reset so no spurious edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[SR_W-2:0], pin_i};
  end

  assign fall_o = sr_q[SR_W-1] & ~sr_q[SR_W-2];

  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/gtp_channel.sv
module gtp_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             run_i,
  input  logic             gate_i,
  input  logic             ct_i,
  input  logic             gate_pin_i,
  input  logic             pd_i,
  input  logic             vec_i,
  input  logic             flag_we_i,
  input  logic             flag_wd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             en, inc, at_max, wrap;

  assign en     = run_i & (~gate_i | gate_pin_i) & ~pd_i;
  assign inc    = en & (ct_i ? fall_i : tick_i);
  assign at_max = &cnt_q;
  assign wrap   = inc & at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // wrap beats software write beats vector clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (wrap)      flag_q <= 1'b1;
    else if (flag_we_i) flag_q <= flag_wd_i;
    else if (vec_i)     flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  assert_hold_stopped_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == $past(cnt_q));

  assert_hold_pd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> cnt_q == $past(cnt_q));

  assert_gate_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !gate_pin_i) |=> cnt_q == $past(cnt_q));

  assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_wrap_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cnt_q) == '1) && (cnt_q == '0)) |-> flag_q);

  assert_vec_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i && !flag_we_i && !wrap) |=> !flag_q);

  assert_no_lost_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);
endmodule

// File: rtl/gate_timer_pair.sv
module gate_timer_pair
  import gtp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pd_i,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_wdata_i,
  input  logic             mode_we_i,
  input  logic [7:0]       mode_wdata_i,
  input  logic [1:0]       gate_pin_i,
  input  logic [1:0]       cnt_pin_i,
  input  logic [1:0]       vec_ack_i,
  output logic [7:0]       ctl_o,
  output logic [7:0]       mode_o,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [CNT_W-1:0] cnt1_o,
  output logic [1:0]       ovf_o
);
  logic [7:0]       ctl_q;    // flag positions unused here, flags live in channels
  logic [7:0]       mode_q;
  logic [CNT_W-1:0] cnt_w [NUM_CH];
  logic [NUM_CH-1:0] flag_w;
  logic [NUM_CH-1:0] fall_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wdata_i;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    gtp_fall_det #(.SYNC_STAGES(SYNC_STAGES)) i_fall (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cnt_pin_i[ch]),
      .fall_o (fall_w[ch])
    );

    gtp_channel #(.CNT_W(CNT_W)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .fall_i     (fall_w[ch]),
      .run_i      (ctl_q[ctl_run_bit(ch)]),
      .gate_i     (mode_q[mode_gate_bit(ch)]),
      .ct_i       (mode_q[mode_ct_bit(ch)]),
      .gate_pin_i (gate_pin_i[ch]),
      .pd_i       (pd_i),
      .vec_i      (vec_ack_i[ch]),
      .flag_we_i  (ctl_we_i),
      .flag_wd_i  (ctl_wdata_i[ctl_flag_bit(ch)]),
      .cnt_o      (cnt_w[ch]),
      .flag_o     (flag_w[ch])
    );
  end

  always_comb begin
    ctl_o = ctl_q;
    for (int ch = 0; ch < NUM_CH; ch++) ctl_o[ctl_flag_bit(ch)] = flag_w[ch];
  end

  assign mode_o = mode_q;
  assign cnt0_o = cnt_w[0];
  assign cnt1_o = cnt_w[1];
  assign ovf_o  = flag_w;

  assert_ctl_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ctl_o[3:0] == $past(ctl_wdata_i[3:0])) &&
                 (ctl_o[6] == $past(ctl_wdata_i[6])) && (ctl_o[4] == $past(ctl_wdata_i[4])));

  assert_mode_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> mode_o == $past(mode_wdata_i));

  assert_flags_mirror_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[7] == ovf_o[1]) && (ctl_o[5] == ovf_o[0]));
endmodule

// File: tb/test_gate_timer_pair.sv
module test_gate_timer_pair;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int MAXV       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0, pd_i = 1'b0;
  logic         ctl_we_i = 1'b0, mode_we_i = 1'b0;
  logic [7:0]   ctl_wdata_i = '0, mode_wdata_i = '0;
  logic [1:0]   gate_pin_i = '0, cnt_pin_i = 2'b11, vec_ack_i = '0;
  logic [7:0]   ctl_o, mode_o;
  logic [W-1:0] cnt0_o, cnt1_o;
  logic [1:0]   ovf_o;

  int errors = 0, checks = 0;

  // bench model state
  logic [1:0] b_run = '0, b_gate = '0, b_ct = '0, exp_flag = '0;
  int exp_cnt [2] = '{0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_timer_pair #(.CNT_W(W)) i_gate_timer_pair (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .pd_i(pd_i),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .mode_we_i(mode_we_i), .mode_wdata_i(mode_wdata_i),
    .gate_pin_i(gate_pin_i), .cnt_pin_i(cnt_pin_i), .vec_ack_i(vec_ack_i),
    .ctl_o(ctl_o), .mode_o(mode_o), .cnt0_o(cnt0_o), .cnt1_o(cnt1_o), .ovf_o(ovf_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one clock: called at negedge, returns at next negedge after checking
  task automatic cyc(input logic tick, input logic [1:0] vec, input logic cwe,
                     input logic [7:0] cval, input logic mwe, input logic [7:0] mval,
                     input string tag);
    logic [1:0] skip;
    tick_i = tick; vec_ack_i = vec; ctl_we_i = cwe; ctl_wdata_i = cval;
    mode_we_i = mwe; mode_wdata_i = mval;
    skip = b_ct;
    for (int ch = 0; ch < 2; ch++) begin
      logic en, inc, wrap;
      en   = b_run[ch] && (!b_gate[ch] || gate_pin_i[ch]) && !pd_i;
      inc  = en && !b_ct[ch] && tick;
      wrap = inc && (exp_cnt[ch] == MAXV);
      if (inc) exp_cnt[ch] = (exp_cnt[ch] + 1) % (MAXV + 1);
      if (wrap)         exp_flag[ch] = 1'b1;
      else if (cwe)     exp_flag[ch] = cval[5 + 2*ch];
      else if (vec[ch]) exp_flag[ch] = 1'b0;
    end
    if (cwe) b_run = {cval[6], cval[4]};
    if (mwe) begin b_gate = {mval[7], mval[3]}; b_ct = {mval[6], mval[2]}; end
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0; vec_ack_i = '0; ctl_we_i = 1'b0; mode_we_i = 1'b0;
    if (!skip[0]) begin
      chk(cnt0_o == W'(exp_cnt[0]), {tag, " cnt0"}, cnt0_o, exp_cnt[0]);
      chk(ovf_o[0] == exp_flag[0], {tag, " flag0"}, ovf_o[0], exp_flag[0]);
    end
    if (!skip[1]) begin
      chk(cnt1_o == W'(exp_cnt[1]), {tag, " cnt1"}, cnt1_o, exp_cnt[1]);
      chk(ovf_o[1] == exp_flag[1], {tag, " flag1"}, ovf_o[1], exp_flag[1]);
    end
  endtask

  function automatic logic [7:0] mk_ctl(input logic r1, input logic r0);
    return {exp_flag[1], r1, exp_flag[0], r0, 4'h0};
  endfunction

  task automatic wr_ctl(input logic [7:0] v, input string tag);
    cyc(1'b0, 2'b00, 1'b1, v, 1'b0, 8'h00, tag);
  endtask

  task automatic wr_mode(input logic [7:0] v, input string tag);
    cyc(1'b0, 2'b00, 1'b0, 8'h00, 1'b1, v, tag);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=%0h exp=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt0_o == '0 && cnt1_o == '0, "R1 counts", {cnt1_o, cnt0_o}, 0);
    chk(ctl_o == 8'h00, "R1 ctl", ctl_o, 0);
    chk(mode_o == 8'h00, "R1 mode", mode_o, 0);
    chk(ovf_o == 2'b00, "R1 flags", ovf_o, 0);

    // R2 readback (run bits off so nothing counts)
    wr_mode(8'h33, "R2");
    chk(mode_o == 8'h33, "R2 mode", mode_o, 8'h33);
    wr_mode(8'h00, "R2");
    wr_ctl(8'h0A, "R2");
    chk(ctl_o == 8'h0A, "R2 ctl", ctl_o, 8'h0A);
    wr_ctl(8'hA5, "R2");
    chk(ctl_o == 8'hA5, "R2 ctl flags", ctl_o, 8'hA5);
    wr_ctl(8'h00, "R2");

    // R3 R4 R5 R10 R11: sweep run/gate/pin/pd on both channels
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [3:0] c;
      c = 4'(cfg);
      pd_i = c[3];
      gate_pin_i = {c[0], c[2]};
      wr_mode({c[2], 3'b000, c[1], 3'b000}, "R5");
      wr_ctl(mk_ctl(c[1], c[0]), "R4");
      for (int k = 0; k < 5; k++) cyc(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R3/R4/R5/R10/R11");
      cyc(1'b0, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R3 no tick");
    end
    pd_i = 1'b0; gate_pin_i = 2'b00;
    wr_mode(8'h00, "R5");
    wr_ctl(mk_ctl(1'b0, 1'b0), "R4");

    // R8 acknowledge clears only its channel
    wr_ctl(8'hA0, "R9 sw set");
    cyc(1'b0, 2'b01, 1'b0, 8'h00, 1'b0, 8'h00, "R8 ack0");
    chk(ovf_o == 2'b10, "R8 other kept", ovf_o, 2'b10);
    cyc(1'b0, 2'b10, 1'b0, 8'h00, 1'b0, 8'h00, "R8 ack1");

    // R7 R9: wrap vs software clear in same cycle
    wr_ctl(mk_ctl(1'b0, 1'b1), "R9");
    while (exp_cnt[0] != MAXV) cyc(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
    cyc(1'b1, 2'b00, 1'b1, 8'h10, 1'b0, 8'h00, "R7/R9 wrap beats write");
    chk(cnt0_o == '0 && ovf_o[0], "R7 wrap", {ovf_o[0], cnt0_o}, 16);
    wr_ctl(8'h10, "R9 sw clear");
    chk(ovf_o[0] == 1'b0, "R9 sw clear", ovf_o[0], 0);
    while (exp_cnt[0] != MAXV) cyc(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R3");
    cyc(1'b1, 2'b01, 1'b0, 8'h00, 1'b0, 8'h00, "R9 wrap beats ack");
    chk(ovf_o[0] == 1'b1, "R9 wrap beats ack", ovf_o[0], 1);
    cyc(1'b0, 2'b01, 1'b0, 8'h00, 1'b0, 8'h00, "R8");

    // R6 counter mode on channel 0, ticks held high
    wr_mode(8'h04, "R6");
    begin
      int base;
      base = exp_cnt[0];
      for (int p = 0; p < 5; p++) begin
        cnt_pin_i[0] = 1'b0;
        repeat (3) cyc(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R6");
        cnt_pin_i[0] = 1'b1;
        repeat (3) cyc(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R6");
        if (exp_cnt[0] == MAXV) begin exp_cnt[0] = 0; exp_flag[0] = 1'b1; end
        else exp_cnt[0]++;
      end
      chk(cnt0_o == W'(exp_cnt[0]), "R6 edges counted", cnt0_o, exp_cnt[0]);
      chk(ovf_o[0] == exp_flag[0], "R6 flag", ovf_o[0], exp_flag[0]);
      chk(exp_cnt[0] == ((base + 5) % (MAXV + 1)), "R6 model", exp_cnt[0], base + 5);
    end
    wr_mode(8'h00, "R6");
    cyc(1'b1, 2'b00, 1'b0, 8'h00, 1'b0, 8'h00, "R3 back to timer");

    finish_run();
  end
endmodule